// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a general-purpose pin controller that sits behind a small single-cycle register bus. For each pin, software chooses whether the block drives it or only observes it. Software can also set the value driven on output pins and read back the input levels after a synchronizer. In addition, it can ask for an interrupt when an observed pin rises, falls, or both.

Edge events land in a sticky per-pin status word. Software clears that word through a separate write-one-to-clear location. A second-level summary register ORs all pending pin status into one bit, bit 15. That bit is gated by a summary mask to form the single interrupt line. A bus request is accepted on the clock edge where `bus_req` is high. The edge after that returns `bus_ack` with read data.

Register word addresses (`bus_addr`): 0 direction, 1 output value, 2 synchronized input, 3 rising enable, 4 falling enable, 5 pin mask, 6 status (read only), 7 status clear (write one to clear, reads 0), 8 summary (bit 15, write one to clear), 9 summary mask.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all zeros (all pins inputs), `pin_out` is 0 and `irq_o` is 0.
- R2: `pin_oe` equals the direction register (1 = drive). `pin_out` equals the output value register ANDed with the direction register. Both registers read back what was written.
- R3: Reading address 2 returns `pin_in` as seen through a two-flop synchronizer, once the pins have been stable for three clocks.
- R4: A 0-to-1 change on a pin whose rising enable and mask bits are both 1 sets that pin's status bit.
- R5: A 1-to-0 change on a pin whose falling enable and mask bits are both 1 sets that pin's status bit. With falling-only enables, going all-ones, then P, then all-ones leaves status equal to ~P.
- R6: A pin whose mask bit is 0, or whose matching edge enable is 0, never gets a status bit set.
- R7: Status bits stay set until software writes a 1 to the matching bit at address 7. Zeros in that write leave bits unchanged, and address 7 reads 0.
- R8: When an edge event and a clear write hit the same status bit on the same clock edge, the bit stays set.
- R9: Bit 15 of the summary register sets one clock after any status bit is pending. Writing 0x8000 clears it once no status is pending, and all other summary bits read 0.
- R10: `irq_o` is high exactly when summary bit 15 and summary-mask bit 15 are both 1.
- R11: With all enables and masks set, `irq_o` rises on the fourth rising clock edge after a pin edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access done, one cycle after request |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin drive enables |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions rely on a few assumptions about the inputs. Each bus request lasts one cycle and is never repeated before its acknowledge. A clear write carries real zeros in the bits it must spare. `pin_in` is treated as unrelated to the clock, so the sticky and gating checks reason only from the synchronized values. The bench respects these assumptions: it changes `pin_in` and the bus signals only on falling clock edges and issues one access at a time. After every pin change it waits at least four rising edges, except in the latency and same-edge clear tests, which count edges on purpose.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int REG_AW    = 4;
    localparam int GIRQ_BIT  = 15;

    typedef enum logic [REG_AW-1:0] {
        RA_DIR   = 4'd0,
        RA_OUT   = 4'd1,
        RA_IN    = 4'd2,
        RA_RISE  = 4'd3,
        RA_FALL  = 4'd4,
        RA_MASK  = 4'd5,
        RA_STAT  = 4'd6,
        RA_CLR   = 4'd7,
        RA_GSTAT = 4'd8,
        RA_GMASK = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][N-1:0] stg;
        logic [N-1:0]                  prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
        s_d.prev   = s_q.stg[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o  = s_q.stg[LAST];
    assign prev_o = s_q.prev;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] rise_en_i,
    input  logic [N-1:0] fall_en_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o,
    output logic         pending_o
);
    logic [N-1:0] status_d, status_q;
    logic [N-1:0] rise_ev, fall_ev, hit;

    always_comb begin
        rise_ev  = rise_en_i & cur_i & ~prev_i;
        fall_ev  = fall_en_i & ~cur_i & prev_i;
        hit      = mask_i & (rise_ev | fall_ev);
        // a fresh event beats a same-edge clear
        status_d = (status_q & ~clr_i) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_o  = status_q;
    assign pending_o = |status_q;

    // R7: without a clear, no set bit drops
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(|clr_i) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R6: newly set bits must have had mask and some edge enable
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q)
                   & ~$past(mask_i & (rise_en_i | fall_en_i))) == '0));
endmodule

// File: rtl/gpio_glb_irq.sv
module gpio_glb_irq #(
    parameter int W   = 32,
    parameter int BIT = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_i,
    input  logic         clr_i,
    input  logic [W-1:0] gmask_i,
    output logic [W-1:0] glb_o,
    output logic         irq_o
);
    logic glb_d, glb_q;

    always_comb begin
        glb_d = (glb_q & ~clr_i) | src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) glb_q <= 1'b0;
        else        glb_q <= glb_d;
    end

    always_comb begin
        glb_o      = '0;
        glb_o[BIT] = glb_q;
    end

    assign irq_o = glb_q & gmask_i[BIT];

    // R9: pending source latches the summary bit
    a_r9_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
        src_i |=> glb_q);
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int N           = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic              irq_o
);
    typedef struct packed {
        logic [N-1:0]      dir;
        logic [N-1:0]      out;
        logic [N-1:0]      rise;
        logic [N-1:0]      fall;
        logic [N-1:0]      mask;
        logic [DATA_W-1:0] gmask;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [N-1:0]      cur, prev, status, clr_vec;
    logic              pending, gclr;
    logic [DATA_W-1:0] glb;
    logic              wr;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(bus_addr);
    assign wr   = bus_req & bus_we;

    gpio_in_sync #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
        .cur_o(cur), .prev_o(prev)
    );

    gpio_edge_status #(.N(N)) u_status (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
        .rise_en_i(r_q.rise), .fall_en_i(r_q.fall), .mask_i(r_q.mask),
        .clr_i(clr_vec), .status_o(status), .pending_o(pending)
    );

    gpio_glb_irq #(.W(DATA_W), .BIT(GIRQ_BIT)) u_glb (
        .clk(clk), .rst_n(rst_n), .src_i(pending), .clr_i(gclr),
        .gmask_i(r_q.gmask), .glb_o(glb), .irq_o(irq_o)
    );

    always_comb begin
        clr_vec = (wr && addr == RA_CLR) ? bus_wdata[N-1:0] : '0;
        gclr    = wr && addr == RA_GSTAT && bus_wdata[GIRQ_BIT];
    end

    always_comb begin
        r_d       = r_q;
        r_d.ack   = bus_req;
        r_d.rdata = '0;
        if (wr) begin
            case (addr)
                RA_DIR:   r_d.dir   = bus_wdata[N-1:0];
                RA_OUT:   r_d.out   = bus_wdata[N-1:0];
                RA_RISE:  r_d.rise  = bus_wdata[N-1:0];
                RA_FALL:  r_d.fall  = bus_wdata[N-1:0];
                RA_MASK:  r_d.mask  = bus_wdata[N-1:0];
                RA_GMASK: r_d.gmask = bus_wdata;
                default:  ;
            endcase
        end
        if (bus_req && !bus_we) begin
            case (addr)
                RA_DIR:   r_d.rdata = DATA_W'(r_q.dir);
                RA_OUT:   r_d.rdata = DATA_W'(r_q.out);
                RA_IN:    r_d.rdata = DATA_W'(cur);
                RA_RISE:  r_d.rdata = DATA_W'(r_q.rise);
                RA_FALL:  r_d.rdata = DATA_W'(r_q.fall);
                RA_MASK:  r_d.rdata = DATA_W'(r_q.mask);
                RA_STAT:  r_d.rdata = DATA_W'(status);
                RA_GSTAT: r_d.rdata = glb;
                RA_GMASK: r_d.rdata = r_q.gmask;
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_ack   = r_q.ack;
    assign bus_rdata = r_q.rdata;
    assign pin_oe    = r_q.dir;
    assign pin_out   = r_q.out & r_q.dir;

    // R2: a direction write shows on the enables one edge later
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == RA_DIR) |=> (pin_oe == $past(bus_wdata[N-1:0])));

    // R2: an input pin is never driven high
    a_r2_no_drive_in: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    // R10: the line is low whenever the summary mask bit is clear
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.gmask[GIRQ_BIT] |-> !irq_o);
endmodule

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe;
    logic        irq_o;

    int total = 0, bad = 0;
    logic [31:0] rv;
    logic [31:0] pats [8];

    always #2.5 clk = ~clk;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        if (bus_ack !== 1'b1) begin
            total++; bad++;
            $display("FAIL bus got=%b exp=1", bus_ack);
        end
        bus_req = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'h0000_8000);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog got=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pats[0] = 32'h5555_5555; pats[1] = 32'hAAAA_AAAA;
        pats[2] = 32'h5A5A_5A5A; pats[3] = 32'hA5A5_A5A5;
        pats[4] = 32'h0000_0001; pats[5] = 32'h8000_0000;
        pats[6] = 32'h1234_5678; pats[7] = 32'hFFFF_0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 out", pin_out, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), rv);
            chk("R1 reg", rv, 32'h0);
        end

        // R2 direction / output sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                wr(4'd0, pats[i]);
                wr(4'd1, pats[j]);
                chk("R2 oe", pin_oe, pats[i]);
                chk("R2 out", pin_out, pats[i] & pats[j]);
            end
        end
        rd(4'd0, rv); chk("R2 dir rb", rv, pats[7]);
        rd(4'd1, rv); chk("R2 out rb", rv, pats[7]);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h0);

        // R3 input readback, walking ones and patterns
        for (int b = 0; b < 32; b++) begin
            drive(32'h1 << b);
            rd(4'd2, rv);
            chk("R3 walk", rv, 32'h1 << b);
        end
        for (int i = 0; i < 8; i++) begin
            drive(pats[i]);
            rd(4'd2, rv);
            chk("R3 pat", rv, pats[i]);
        end

        // R4 rising, all enabled
        wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 32'h0); wr(4'd5, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            drive(32'h0); clear_all();
            rd(4'd6, rv); chk("R7 cleared", rv, 32'h0);
            drive(pats[i]); drive(32'h0);
            rd(4'd6, rv); chk("R4 rise", rv, pats[i]);
            rd(4'd8, rv); chk("R9 summary", rv, 32'h8000);
            clear_all();
            rd(4'd8, rv); chk("R9 cleared", rv, 32'h0);
        end

        // R5 falling, all enabled
        wr(4'd3, 32'h0); wr(4'd4, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            drive(32'hFFFF_FFFF); clear_all();
            drive(pats[i]); drive(32'hFFFF_FFFF);
            rd(4'd6, rv); chk("R5 fall", rv, ~pats[i]);
            clear_all();
        end

        // R6 gating by mask and enables
        wr(4'd3, 32'h0F0F_0F0F); wr(4'd4, 32'h00FF_00FF); wr(4'd5, 32'h00FF_FF00);
        for (int i = 0; i < 8; i++) begin
            drive(32'h0); clear_all();
            drive(pats[i]); drive(32'h0);
            rd(4'd6, rv);
            chk("R6 gate", rv, (pats[i] & 32'h00FF_FF00) & (32'h0F0F_0F0F | 32'h00FF_00FF));
            clear_all();
        end

        // R7 partial clear, clear register reads 0
        wr(4'd3, 32'hFFFF_FFFF); wr(4'd4, 32'h0); wr(4'd5, 32'hFFFF_FFFF);
        drive(32'h0); clear_all();
        drive(32'hF0F0_F0F0); drive(32'h0);
        wr(4'd7, 32'h0000_FFFF);
        rd(4'd6, rv); chk("R7 partial", rv, 32'hF0F0_0000);
        rd(4'd7, rv); chk("R7 clr reads 0", rv, 32'h0);

        // R9 clear while pending keeps bit, other bits ignored
        wr(4'd8, 32'h0000_8000);
        rd(4'd8, rv); chk("R9 pending hold", rv, 32'h8000);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_7FFF);
        rd(4'd8, rv); chk("R9 other bits", rv, 32'h8000);
        wr(4'd8, 32'h0000_8000);
        rd(4'd8, rv); chk("R9 clear", rv, 32'h0);

        // R10 summary mask gating
        drive(32'h0000_0004); drive(32'h0);
        chk("R10 masked", {31'b0, irq_o}, 32'h0);
        wr(4'd9, 32'h0000_8000);
        chk("R10 enabled", {31'b0, irq_o}, 32'h1);
        wr(4'd9, 32'h0);
        chk("R10 remasked", {31'b0, irq_o}, 32'h0);
        wr(4'd9, 32'h0000_8000);
        clear_all();
        chk("R10 cleared", {31'b0, irq_o}, 32'h0);

        // R11 latency: irq after 4th edge, not 3rd
        @(negedge clk);
        pin_in = 32'h0000_0100;
        repeat (3) @(posedge clk);
        #1 chk("R11 not yet", {31'b0, irq_o}, 32'h0);
        @(posedge clk);
        #1 chk("R11 rise", {31'b0, irq_o}, 32'h1);
        drive(32'h0); clear_all();

        // R8 same-edge event and clear
        drive(32'h1); drive(32'h0);
        rd(4'd6, rv); chk("R8 setup", rv, 32'h1);
        @(negedge clk);
        pin_in = 32'h1;
        repeat (2) @(posedge clk);
        wr(4'd7, 32'h1);
        rd(4'd6, rv); chk("R8 event wins", rv, 32'h1);
        wr(4'd7, 32'h1);
        rd(4'd6, rv); chk("R8 later clear", rv, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule